// File: doc/BRIEF.md
# Nine-Bit Cartridge Bank Controller

This block sits between a CPU's 16-bit address/data bus and a cartridge's ROM and save RAM. Software picks a 16 KB ROM bank by writing two control registers: one holds the low eight bits of the bank number and the other holds the ninth bit. This gives up to 512 banks. Any bank, bank 0 included, can be placed in the switchable window at 0x4000-0x7FFF. The window at 0x0000-0x3FFF always shows the start of ROM.

An 8 KB RAM window at 0xA000-0xBFFF reaches an internal byte array through a 4-bit RAM bank register. RAM must first be enabled with a magic value. For every read the block gives a physical ROM address. For the RAM window it also gives the data byte.

Control writes go to the ROM address range and are taken on the rising clock edge. ROM address and read data follow the bus address combinationally. Register changes therefore show on the outputs in the cycle after the write edge.

Top module: `rom9_bank_ctrl`

## Requirements
- R1: After reset the ROM bank is 0x001, RAM is disabled and the RAM bank is 0.
- R2: A write to 0x0000-0x1FFF enables RAM when the data byte is exactly 0x0A and disables it for any other value.
- R3: A write to 0x2000-0x2FFF loads the data byte into bank bits 7:0 and keeps bit 8. Zero is stored as zero, so bank 0 appears in the switchable window.
- R4: A write to 0x3000-0x3FFF loads data bit 0 into bank bit 8 and keeps bits 7:0.
- R5: A write to 0x4000-0x5FFF loads data bits 3:0 into the RAM bank.
- R6: For a bus address in 0x0000-0x3FFF, `rom_addr` equals the bus address.
- R7: For a bus address in 0x4000-0x7FFF, `rom_addr` is bank × 0x4000 + (address − 0x4000), truncated to ROM_AW bits.
- R8: With RAM enabled, an access in 0xA000-0xBFFF uses offset RAM bank × 0x2000 + (address − 0xA000), truncated to RAM_AW bits. A write stores the byte there and a read returns it on `rd_data`.
- R9: With RAM disabled, reads in 0xA000-0xBFFF return 0xFF and writes there leave the RAM unchanged.
- R10: `rom_sel` is high exactly for addresses below 0x8000. `rd_data` is 0xFF outside the RAM window. Writes to 0x6000-0x7FFF or at 0x8000 and above, outside the RAM window, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | CPU bus address |
| bus_wdata | input | 8 | CPU write data |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| rom_addr | output | ROM_AW | Physical ROM byte address |
| rom_sel | output | 1 | High while the bus address is in ROM space |
| rd_data | output | 8 | RAM read byte, 0xFF when no RAM byte is driven |

## Verification
A write into the RAM window and a read of that same location happen in the same bus cycle. The write is taken at the closing edge, while `rd_data` is combinational from the address.

The bench drives writes and reads to the same address back to back and compares `rd_data` in every cycle, write cycles included. During the write cycle it must show the old byte, and on the next cycle the new one.

A write to either bank register is judged the same way. `rom_addr` for a switchable-window address keeps the old bank until the write edge and changes right after it.

// File: rtl/rom9_bank_ctrl.sv
module rom9_bank_ctrl #(
  parameter int ROM_AW = 23,
  parameter int RAM_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_sel,
  output logic [7:0]        rd_data
);
  localparam int RAM_BYTES = 1 << RAM_AW;

  logic [8:0]        rom_bank;
  logic              ram_en;
  logic [3:0]        ram_bank;
  logic [7:0]        mem [RAM_BYTES];
  logic [RAM_AW-1:0] ram_off;
  logic              in_ram, wr_en_reg, wr_lo, wr_hi, wr_rb;

  assign in_ram    = bus_addr[15:13] == 3'b101;
  assign wr_en_reg = bus_wr && bus_addr[15:13] == 3'b000;
  assign wr_lo     = bus_wr && bus_addr[15:12] == 4'h2;
  assign wr_hi     = bus_wr && bus_addr[15:12] == 4'h3;
  assign wr_rb     = bus_wr && bus_addr[15:13] == 3'b010;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_bank <= 9'h001;
      ram_en   <= 1'b0;
      ram_bank <= 4'h0;
    end else begin
      if (wr_en_reg) ram_en        <= bus_wdata == 8'h0A;
      if (wr_lo)     rom_bank[7:0] <= bus_wdata;
      if (wr_hi)     rom_bank[8]   <= bus_wdata[0];
      if (wr_rb)     ram_bank      <= bus_wdata[3:0];
    end
  end

  assign ram_off = RAM_AW'({ram_bank, bus_addr[12:0]});

  always_ff @(posedge clk) begin
    if (bus_wr && in_ram && ram_en) mem[ram_off] <= bus_wdata;
  end

  assign rom_addr = bus_addr[14] ? ROM_AW'({rom_bank, bus_addr[13:0]})
                                 : ROM_AW'(bus_addr[13:0]);
  assign rom_sel  = !bus_addr[15];
  assign rd_data  = (in_ram && ram_en) ? mem[ram_off] : 8'hFF;
endmodule

// File: rtl/rom9_bank_ctrl_chk.sv
module rom9_bank_ctrl_chk #(
  parameter int ROM_AW = 23
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              bus_wr,
  input logic [ROM_AW-1:0] rom_addr,
  input logic [7:0]        rd_data,
  input logic [8:0]        rom_bank,
  input logic              ram_en,
  input logic [3:0]        ram_bank
);
  logic ctl_wr;
  assign ctl_wr = bus_wr && !bus_addr[15] && bus_addr[15:13] != 3'b011;

  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rom_bank == 9'h001 && !ram_en && ram_bank == 4'h0));

  a_r2_enable_key: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[15:13] == 3'b000) |=> (ram_en == ($past(bus_wdata) == 8'h0A)));

  a_r3_low_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[15:12] == 4'h2) |=>
      (rom_bank[7:0] == $past(bus_wdata) && rom_bank[8] == $past(rom_bank[8])));

  a_r4_high_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[15:12] == 4'h3) |=>
      (rom_bank[8] == $past(bus_wdata[0]) && rom_bank[7:0] == $past(rom_bank[7:0])));

  a_r5_ram_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[15:13] == 3'b010) |=> (ram_bank == $past(bus_wdata[3:0])));

  a_r6_direct_map: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[15:14] == 2'b00) |-> (rom_addr == ROM_AW'(bus_addr)));

  a_r9_disabled_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[15:13] == 3'b101 && !ram_en) |-> (rd_data == 8'hFF));

  a_r10_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> ($stable(rom_bank) && $stable(ram_en) && $stable(ram_bank)));
endmodule

bind rom9_bank_ctrl rom9_bank_ctrl_chk #(.ROM_AW(ROM_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .rom_addr(rom_addr), .rd_data(rd_data),
  .rom_bank(rom_bank), .ram_en(ram_en), .ram_bank(ram_bank)
);

// File: tb/rom9_bank_ctrl_tb.sv
module rom9_bank_ctrl_tb;
  localparam int ROM_AW = 23;
  localparam int RAM_AW = 14;
  localparam int RAM_BYTES = 1 << RAM_AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic [7:0]  bus_wdata = 8'h00;
  logic        bus_wr = 1'b0;
  logic [ROM_AW-1:0] rom_addr;
  logic rom_sel;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;

  int m_bank, m_rbank;
  bit m_en;
  byte unsigned m_mem [RAM_BYTES];
  bit m_valid [RAM_BYTES];

  always #4 clk = ~clk;

  rom9_bank_ctrl #(.ROM_AW(ROM_AW), .RAM_AW(RAM_AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .rom_addr(rom_addr), .rom_sel(rom_sel), .rd_data(rd_data)
  );

  function automatic int ram_idx(int a, int rb);
    return (rb * 'h2000 + (a - 'hA000)) % RAM_BYTES;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_bank = 1; m_en = 0; m_rbank = 0;
    end else if (bus_wr) begin
      int a;
      a = int'(bus_addr);
      if (a < 'h2000) m_en = (bus_wdata == 8'h0A);
      else if (a < 'h3000) m_bank = (m_bank & 'h100) | int'(bus_wdata);
      else if (a < 'h4000) m_bank = (m_bank & 'hFF) | (int'(bus_wdata[0]) << 8);
      else if (a < 'h6000) m_rbank = int'(bus_wdata) & 'hF;
      else if (a >= 'hA000 && a < 'hC000 && m_en) begin
        m_mem[ram_idx(a, m_rbank)] = bus_wdata;
        m_valid[ram_idx(a, m_rbank)] = 1;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h (addr=0x%04h)", tag, act, exp, bus_addr);
    end
  endtask

  task automatic compare();
    int a, e;
    a = int'(bus_addr);
    chk("R10 rom_sel", int'(rom_sel), int'(a < 'h8000));
    if (a < 'h4000) chk("R6 rom_addr", int'(rom_addr), a);
    else if (a < 'h8000) begin
      e = (m_bank * 'h4000 + (a - 'h4000)) % (1 << ROM_AW);
      chk("R7 rom_addr", int'(rom_addr), e);
    end
    if (a >= 'hA000 && a < 'hC000) begin
      if (!m_en) chk("R9 rd_data", int'(rd_data), 'hFF);
      else if (m_valid[ram_idx(a, m_rbank)])
        chk("R8 rd_data", int'(rd_data), int'(m_mem[ram_idx(a, m_rbank)]));
    end else chk("R10 rd_data", int'(rd_data), 'hFF);
  endtask

  task automatic step(int a, int d, bit w);
    @(negedge clk);
    bus_addr = 16'(a); bus_wdata = 8'(d); bus_wr = w;
    #2 compare();
  endtask

  task automatic rd(int a); step(a, 0, 0); endtask
  task automatic wr(int a, int d); step(a, d, 1); endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state seen at ports
    rd('h4000); chk("R1 bank after reset", int'(rom_addr), 'h4000);
    rd('hA000); chk("R1 RAM disabled after reset", int'(rd_data), 'hFF);
    // R6
    rd('h0000); rd('h1234); rd('h3FFF);
    // R3: bank 0 in window, full byte
    wr('h2000, 'h00); rd('h4000); chk("R3 bank zero", int'(rom_addr), 'h0);
    wr('h2FFF, 'hFF); rd('h4001); chk("R3 bank 0xFF", int'(rom_addr), 'hFF * 'h4000 + 1);
    // R4: ninth bit, low bits kept
    wr('h3000, 'h01); rd('h7FFF); chk("R4 bank 0x1FF", int'(rom_addr), 'h1FF * 'h4000 + 'h3FFF);
    wr('h2000, 'h05); rd('h4000); chk("R3 keeps bit8", int'(rom_addr), 'h105 * 'h4000);
    wr('h3ABC, 'hFE); rd('h4000); chk("R4 clears bit8", int'(rom_addr), 'h05 * 'h4000);
    // same-cycle: bank write while window read follows
    wr('h3000, 'h03); rd('h5000); chk("R4 data bit0 only", int'(rom_addr), 'h105 * 'h4000 + 'h1000);
    // R2
    wr('h0000, 'h0A); rd('hA000);
    wr('hA000, 'h11); rd('hA000); chk("R8 stored byte", int'(rd_data), 'h11);
    wr('h1FFF, 'h1A); rd('hA000); chk("R2 non-key disables", int'(rd_data), 'hFF);
    wr('hA000, 'h55);
    wr('h1000, 'h0A); rd('hA000); chk("R9 disabled write dropped", int'(rd_data), 'h11);
    // same address write then read back to back
    wr('hA123, 'h21); wr('hA123, 'h22); rd('hA123); chk("R8 write-read", int'(rd_data), 'h22);
    // R5 / R8: banks and masking
    wr('h4000, 'h01); wr('hA010, 'hB1);
    wr('h5FFF, 'h00); wr('hA010, 'hB0);
    rd('hA010); chk("R8 bank0 byte", int'(rd_data), 'hB0);
    wr('h4000, 'h01); rd('hA010); chk("R5 bank1 byte", int'(rd_data), 'hB1);
    wr('h4000, 'h02); rd('hA010); chk("R8 bank2 aliases bank0", int'(rd_data), 'hB0);
    wr('h4000, 'hFF); rd('hA010); chk("R5 low nibble 0xF aliases bank1", int'(rd_data), 'hB1);
    // R10: ignored writes
    wr('h6000, 'h00); wr('h8000, 'h00); wr('hC000, 'h00); wr('hFFFF, 'h0A);
    rd('h4000); chk("R10 bank unchanged", int'(rom_addr), 'h105 * 'h4000);
    rd('hA010); chk("R10 RAM state unchanged", int'(rd_data), 'hB1);
    rd('h8000); chk("R10 rom_sel low", int'(rom_sel), 0);
    // mixed traffic compared every cycle
    for (int i = 0; i < 3000; i++) begin
      int a, d, r;
      r = int'($urandom_range(0, 9));
      d = int'($urandom_range(0, 255));
      if (r == 0) d = 'h0A;
      case ($urandom_range(0, 7))
        0: a = int'($urandom_range(0, 'h1FFF));
        1: a = int'($urandom_range('h2000, 'h3FFF));
        2: a = int'($urandom_range('h4000, 'h7FFF));
        3: a = int'($urandom_range('h8000, 'hFFFF));
        default: a = 'hA000 + int'($urandom_range(0, 63));
      endcase
      step(a, d, r < 5);
    end
    @(negedge clk);
    bus_wr = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule